// File: doc/BRIEF.md
# Pipelined control word generator

This block decodes the opcode of the instruction in the decode stage of a five-stage load/store pipeline. It turns the opcode into a nine-bit control word. The word has three groups: an execute group (destination select, two-bit ALU operation class, immediate operand select), a memory group (branch, memory read, memory write) and a writeback group (register write enable, write data from memory).

The word moves down the pipeline with its instruction. Each group is dropped once the stage that uses it has passed. The decode-to-execute register holds all nine bits. The execute-to-memory register holds the five memory and writeback bits. The memory-to-writeback register holds only the two writeback bits, so the block stores sixteen control flip-flops in total.

Two control inputs alter the flow of words through the registers:
- A bubble request replaces the word entering execute with a nop.
- A flush request squashes both the word entering execute and the word entering the memory stage.

Top module: `pipe_ctrl_gen`

## Requirements
- R1: An active-low asynchronous reset clears all three stage registers, so every control output reads 0 while reset is low.
- R2: Opcode 6'h00 (register format) decodes to execute group {dst_rd,alu_op[1:0],alu_imm}=4'b1100, memory group {branch,mem_rd,mem_wr}=3'b000 and writeback group {reg_we,from_mem}=2'b10.
- R3: Opcode 6'h23 (load) decodes to execute 4'b0001, memory 3'b010 and writeback 2'b11; the destination select is 0 because a load writes its rt field.
- R4: Opcode 6'h2b (store) decodes to execute 4'b0001, memory 3'b001 and writeback 2'b00, with the don't-care bits driven to 0.
- R5: Opcode 6'h04 (branch on equal) decodes to execute 4'b0010, memory 3'b100 and writeback 2'b00.
- R6: Any other opcode decodes to an all-zero word, which behaves as a nop in every stage.
- R7: The timing of each group follows the clock edge that samples the opcode. The execute group appears after that edge, the memory group one edge later and the writeback group one edge after that. Each of these moves happens on every clock.
- R8: While the bubble request is high at an edge, the execute stage receives an all-zero word. On that same edge, the words already in execute and memory advance normally.
- R9: While the flush request is high at an edge, the execute stage and the memory stage both receive all-zero words. On that same edge, the writeback stage still takes the word that was in the memory stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode of the instruction in decode |
| bubble | input | 1 | Insert a nop into execute |
| flush | input | 1 | Squash the words entering execute and memory |
| ex_dst_rd | output | 1 | Execute stage: destination is rd (1) or rt (0) |
| ex_alu_op | output | 2 | Execute stage: ALU operation class |
| ex_alu_imm | output | 1 | Execute stage: second ALU operand is the immediate |
| mem_branch | output | 1 | Memory stage: instruction is a conditional branch |
| mem_rd | output | 1 | Memory stage: data memory read |
| mem_wr | output | 1 | Memory stage: data memory write |
| wb_reg_we | output | 1 | Writeback stage: register file write enable |
| wb_from_mem | output | 1 | Writeback stage: write data comes from memory |

## Verification
Each stage shows a different instruction's group, so every check depends on knowing which instruction sits in each register at the time. That is hardest for a bubble or flush that arrives while all three stages hold different instruction classes. A stream of distinct classes is therefore fed edge by edge, and bubble or flush is raised with a load and a register-format word already in flight. The bench then checks on the following edges that only the intended stages go to zero while older words still reach writeback. A reset asserted mid-stream, with all registers holding non-zero words, checks the asynchronous clear.

// File: rtl/pipe_ctrl_gen.sv
module pipe_ctrl_gen #(
  parameter int OPC_W = 6,
  parameter logic [OPC_W-1:0] OP_REG   = 6'h00,
  parameter logic [OPC_W-1:0] OP_LOAD  = 6'h23,
  parameter logic [OPC_W-1:0] OP_STORE = 6'h2b,
  parameter logic [OPC_W-1:0] OP_BEQ   = 6'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic             bubble,
  input  logic             flush,
  output logic             ex_dst_rd,
  output logic [1:0]       ex_alu_op,
  output logic             ex_alu_imm,
  output logic             mem_branch,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             wb_reg_we,
  output logic             wb_from_mem
);

  localparam int EX_W  = 4;
  localparam int MEM_W = 3;
  localparam int WB_W  = 2;
  localparam int LATE_W = MEM_W + WB_W;
  localparam int WORD_W = EX_W + LATE_W;

  logic [WORD_W-1:0] dec_word;

  always_comb begin
    case (opcode)
      OP_REG:   dec_word = {4'b1100, 3'b000, 2'b10};
      OP_LOAD:  dec_word = {4'b0001, 3'b010, 2'b11};
      OP_STORE: dec_word = {4'b0001, 3'b001, 2'b00};
      OP_BEQ:   dec_word = {4'b0010, 3'b100, 2'b00};
      default:  dec_word = '0;
    endcase
  end

  logic [WORD_W-1:0] idex_q;
  logic [LATE_W-1:0] exmem_q;
  logic [WB_W-1:0]   memwb_q;

  wire [WORD_W-1:0] idex_d  = (bubble | flush) ? '0 : dec_word;
  wire [LATE_W-1:0] exmem_d = flush ? '0 : idex_q[LATE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idex_q  <= '0;
      exmem_q <= '0;
      memwb_q <= '0;
    end else begin
      idex_q  <= idex_d;
      exmem_q <= exmem_d;
      memwb_q <= exmem_q[WB_W-1:0];
    end
  end

  assign {ex_dst_rd, ex_alu_op, ex_alu_imm} = idex_q[WORD_W-1:LATE_W];
  assign {mem_branch, mem_rd, mem_wr}       = exmem_q[LATE_W-1:WB_W];
  assign {wb_reg_we, wb_from_mem}           = memwb_q;

endmodule

// File: rtl/pipe_ctrl_gen_chk.sv
module pipe_ctrl_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] opcode,
  input logic       bubble,
  input logic       flush,
  input logic       ex_dst_rd,
  input logic [1:0] ex_alu_op,
  input logic       ex_alu_imm,
  input logic       mem_branch,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       wb_reg_we,
  input logic       wb_from_mem
);
  wire [3:0] ex_g  = {ex_dst_rd, ex_alu_op, ex_alu_imm};
  wire [2:0] mem_g = {mem_branch, mem_rd, mem_wr};
  wire       pass  = !bubble && !flush;

  a_r8_bubble_nop: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> ex_g == 4'b0000);

  a_r9_flush_squash: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ex_g == 4'b0000 && mem_g == 3'b000));

  a_r3_load_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (pass && opcode == 6'h23) |=> ex_g == 4'b0001);

  a_r5_beq_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (pass && opcode == 6'h04) |=> ex_g == 4'b0010);

  a_r7_load_reaches_wb: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (wb_from_mem && wb_reg_we));

  a_r4_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mem_g) <= 1);

  a_r6_wb_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    wb_from_mem |-> wb_reg_we);
endmodule

bind pipe_ctrl_gen pipe_ctrl_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .opcode(opcode), .bubble(bubble), .flush(flush),
  .ex_dst_rd(ex_dst_rd), .ex_alu_op(ex_alu_op), .ex_alu_imm(ex_alu_imm),
  .mem_branch(mem_branch), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .wb_reg_we(wb_reg_we), .wb_from_mem(wb_from_mem)
);

// File: tb/pipe_ctrl_gen_tb.sv
module pipe_ctrl_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'h3f;
  logic       bubble = 1'b0;
  logic       flush = 1'b0;
  logic       ex_dst_rd, ex_alu_imm, mem_branch, mem_rd, mem_wr, wb_reg_we, wb_from_mem;
  logic [1:0] ex_alu_op;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  pipe_ctrl_gen u_dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .bubble(bubble), .flush(flush),
    .ex_dst_rd(ex_dst_rd), .ex_alu_op(ex_alu_op), .ex_alu_imm(ex_alu_imm),
    .mem_branch(mem_branch), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .wb_reg_we(wb_reg_we), .wb_from_mem(wb_from_mem)
  );

  wire [3:0] ex_w  = {ex_dst_rd, ex_alu_op, ex_alu_imm};
  wire [3:0] mem_w = {1'b0, mem_branch, mem_rd, mem_wr};
  wire [3:0] wb_w  = {2'b00, wb_reg_we, wb_from_mem};

  // entry: {opcode, ex group, mem group, wb group}
  localparam int NV = 10;
  localparam logic [14:0] VEC [NV] = '{
    {6'h00, 4'b1100, 3'b000, 2'b10},
    {6'h23, 4'b0001, 3'b010, 2'b11},
    {6'h2b, 4'b0001, 3'b001, 2'b00},
    {6'h04, 4'b0010, 3'b100, 2'b00},
    {6'h3f, 4'b0000, 3'b000, 2'b00},
    {6'h00, 4'b1100, 3'b000, 2'b10},
    {6'h02, 4'b0000, 3'b000, 2'b00},
    {6'h23, 4'b0001, 3'b010, 2'b11},
    {6'h04, 4'b0010, 3'b100, 2'b00},
    {6'h2b, 4'b0001, 3'b001, 2'b00}
  };

  function automatic string tag_of(logic [5:0] op);
    case (op)
      6'h00:   return "R2";
      6'h23:   return "R3";
      6'h2b:   return "R4";
      6'h04:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b expected=%b", tag, got, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog got=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #5;
    chk("R1 ex in reset", ex_w, 4'b0000);
    chk("R1 mem in reset", mem_w, 4'b0000);
    chk("R1 wb in reset", wb_w, 4'b0000);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    // R7 streaming through the table: ex lags 1 edge, mem 2, wb 3
    for (int i = 0; i < NV + 3; i++) begin
      @(negedge clk);
      if (i >= 1 && i - 1 < NV)
        chk({tag_of(VEC[i-1][14:9]), " R7 ex"}, ex_w, VEC[i-1][8:5]);
      if (i >= 2 && i - 2 < NV)
        chk({tag_of(VEC[i-2][14:9]), " R7 mem"}, mem_w, {1'b0, VEC[i-2][4:2]});
      if (i >= 3 && i - 3 < NV)
        chk({tag_of(VEC[i-3][14:9]), " R7 wb"}, wb_w, {2'b00, VEC[i-3][1:0]});
      opcode = (i < NV) ? VEC[i][14:9] : 6'h3f;
    end

    // R8 bubble behind a load
    opcode = 6'h23;
    @(negedge clk);
    opcode = 6'h00; bubble = 1'b1;
    @(negedge clk);
    chk("R8 ex zeroed", ex_w, 4'b0000);
    chk("R8 load advances to mem", mem_w, 4'b0010);
    opcode = 6'h2b; bubble = 1'b0;
    @(negedge clk);
    chk("R8 next word enters ex", ex_w, 4'b0001);
    chk("R8 bubble nop in mem", mem_w, 4'b0000);
    chk("R8 load reaches wb", wb_w, 4'b0011);

    // R9 flush with load in ex and register-format in mem
    opcode = 6'h00;
    @(negedge clk);
    opcode = 6'h23;
    @(negedge clk);
    opcode = 6'h2b; flush = 1'b1;
    @(negedge clk);
    chk("R9 ex squashed", ex_w, 4'b0000);
    chk("R9 mem squashed", mem_w, 4'b0000);
    chk("R9 wb keeps older word", wb_w, 4'b0010);
    opcode = 6'h04; flush = 1'b0;
    @(negedge clk);
    chk("R9 ex resumes", ex_w, 4'b0010);
    chk("R9 mem still nop", mem_w, 4'b0000);
    chk("R9 squashed load gives no wb", wb_w, 4'b0000);

    // R1 asynchronous reset mid-stream
    opcode = 6'h23;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R1 pipe full before reset", wb_w, 4'b0011);
    rst_n = 1'b0;
    #1;
    chk("R1 ex cleared", ex_w, 4'b0000);
    chk("R1 mem cleared", mem_w, 4'b0000);
    chk("R1 wb cleared", wb_w, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    opcode = 6'h3f;
    @(negedge clk);
    chk("R6 unknown after reset", ex_w, 4'b0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule